// File: doc/BRIEF.md
# System Tick Timer

A 24-bit periodic down-counter with four word registers on a plain single-cycle bus. A processor uses it to produce a steady time base. It sets a reload value, picks either the core clock or a slow external reference as the count source, and enables counting. It can also enable an interrupt request. Each time the count passes through zero, a sticky status flag is raised and, if enabled, a one-cycle interrupt pulse is produced.

Software polls the flag by reading the control word, and that read clears the flag. Writing the count register restarts the period. A read-only calibration word reports a reload value for a 10 ms period, together with two quality indicators. All three calibration values are set by parameters.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word reads 0 (counting and interrupt off), the reload and count registers read 0, and `irq` is low.
- R2: The control word at offset 0x0 holds the count enable in bit 0, the interrupt enable in bit 1 and the source select in bit 2 (1 = core clock, 0 = external reference). All three read back as written. Bit 16 shows the flag, and writes to bit 16 have no effect.
- R3: The reload register at offset 0x4 keeps only bits 23:0 of the written data. Bits 31:24 read as zero.
- R4: Read data appears on `bus_rdata` one cycle after the read request. The word at offset 0xC reads {CAL_NOREF in bit 31, CAL_SKEW in bit 30, zeros in bits 29:24, CAL_TENMS in bits 23:0}, and writes to it are ignored.
- R5: Any write to offset 0x8 sets the count to zero and clears the flag, whatever the data.
- R6: While counting is enabled, each selected tick loads the reload value if the count is 0 and otherwise decrements it. While counting is disabled, the count holds.
- R7: A tick that finds the count at 1 sets the flag. When the interrupt enable is set, the same tick makes `irq` high for exactly the following cycle.
- R8: A read of offset 0x0 clears the flag. If a wrap happens in the same cycle as that read, the flag stays set.
- R9: With a reload value of zero, the count stays at zero and neither the flag nor `irq` is ever raised.
- R10: With the external source selected, a tick occurs once per rising edge of `ext_ref`, after a two-flop synchronizer. With the core clock selected, every cycle is a tick.

Port order follows the top module's port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| ext_ref | input | 1 | Asynchronous external reference clock |
| irq | output | 1 | One-cycle interrupt pulse on wrap |

## Verification
A wrong count or reload state shows up on `irq` within one period, because the pulse lands one or more cycles off the spacing of reload+1 ticks. It also shows up on the next read of offset 0x8. A flag that is lost or stuck shows on the next control-word read, so reads that land on the wrap cycle are the sensitive case. The bench keeps its own model of the registers, drives random traffic and external edges through it, and compares `irq` every cycle and every read result one cycle after its request.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W = 24,
  parameter logic [CNT_W-1:0] CAL_TENMS = 24'd249_999,
  parameter bit CAL_NOREF = 1'b0,
  parameter bit CAL_SKEW = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_valid,
  input  logic        bus_write,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        ext_ref,
  output logic        irq
);
  localparam logic [1:0] SEL_CTL = 2'd0, SEL_REL = 2'd1, SEL_CUR = 2'd2;

  logic             en, tie, src, flag;
  logic [CNT_W-1:0] rel, cnt;
  logic [2:0]       ext_s;
  logic [31:0]      rd_mux;

  wire [1:0] sel    = bus_addr[3:2];
  wire       wr     = bus_valid & bus_write;
  wire       rd     = bus_valid & ~bus_write;
  wire       cur_wr = wr && sel == SEL_CUR;
  wire       ctl_rd = rd && sel == SEL_CTL;
  wire       tick   = src | (ext_s[1] & ~ext_s[2]);
  wire       step   = en & tick & ~cur_wr;
  wire       wrap   = step && cnt == CNT_W'(1);

  always_comb begin
    case (sel)
      SEL_CTL: rd_mux = {15'b0, flag, 13'b0, src, tie, en};
      SEL_REL: rd_mux = 32'(rel);
      SEL_CUR: rd_mux = 32'(cnt);
      default: rd_mux = {CAL_NOREF, CAL_SKEW, 30'(CAL_TENMS)};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en, tie, src, flag} <= '0;
      rel       <= '0;
      cnt       <= '0;
      ext_s     <= '0;
      irq       <= 1'b0;
      bus_rdata <= '0;
    end else begin
      ext_s <= {ext_s[1:0], ext_ref};
      irq   <= wrap & tie;
      if (rd) bus_rdata <= rd_mux;
      if (wr && sel == SEL_CTL) {src, tie, en} <= bus_wdata[2:0];
      if (wr && sel == SEL_REL) rel <= bus_wdata[CNT_W-1:0];
      if (cur_wr)    cnt <= '0;
      else if (step) cnt <= (cnt == '0) ? rel : cnt - CNT_W'(1);
      if (wrap)                  flag <= 1'b1;
      else if (cur_wr || ctl_rd) flag <= 1'b0;
    end
  end
endmodule

module tick_timer_chk #(parameter int CNT_W = 24) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq,
  input logic             tie,
  input logic             en,
  input logic             flag,
  input logic             cur_wr,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] rel
);
  AST_IRQ_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R7
  AST_IRQ_GATED:    assert property (@(posedge clk) disable iff (!rst_n) irq |-> $past(tie)); // R7
  AST_IRQ_FLAGGED:  assert property (@(posedge clk) disable iff (!rst_n) irq |-> flag); // R7
  AST_CUR_CLEAR:    assert property (@(posedge clk) disable iff (!rst_n) cur_wr |=> (cnt == '0 && !flag)); // R5
  AST_HOLD_OFF:     assert property (@(posedge clk) disable iff (!rst_n) (!en && !cur_wr) |=> $stable(cnt)); // R6
  AST_ZERO_RELOAD:  assert property (@(posedge clk) disable iff (!rst_n) (cnt == '0 && rel == '0) |=> (cnt == '0 && !irq)); // R9
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .irq(irq), .tie(tie), .en(en), .flag(flag),
  .cur_wr(cur_wr), .cnt(cnt), .rel(rel)
);

// File: tb/tick_timer_tb.sv
module tick_timer_tb_top;
  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0, ext_ref = 0;
  logic [3:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic irq;
  int tests = 0, fails = 0;
  bit done = 0;

  localparam logic [23:0] TENMS = 24'd249_999;

  tick_timer dut_i (.*);

  always #2 clk = ~clk;

  logic m_en, m_tie, m_src, m_flag, m_irq, m_pend;
  logic [23:0] m_rel, m_cnt;
  logic [2:0] m_s;
  logic [31:0] m_rd;
  string m_tag;

  function automatic logic [31:0] exp_read(logic [3:0] a);
    case (a[3:2])
      2'd0: return {15'b0, m_flag, 13'b0, m_src, m_tie, m_en};
      2'd1: return {8'b0, m_rel};
      2'd2: return {8'b0, m_cnt};
      default: return {1'b0, 1'b1, 6'b0, TENMS};
    endcase
  endfunction

  function automatic string def_tag(logic [3:0] a);
    case (a[3:2]) 2'd0: return "R8"; 2'd1: return "R3"; 2'd2: return "R6"; default: return "R4"; endcase
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (!ok) begin fails++; $display("FAIL %s actual=%h expected=%h", tag, act, exp); end
  endtask

  task automatic cyc(bit v, bit w, logic [3:0] a, logic [31:0] d, bit x, string tag = "");
    bit rise, tk, cw, stp, wrp;
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; ext_ref = x;
    @(posedge clk);
    rise = m_s[1] & ~m_s[2];
    tk   = m_src | rise;
    cw   = v && w && a[3:2] == 2'd2;
    stp  = m_en && tk && !cw;
    wrp  = stp && m_cnt == 24'd1;
    m_pend = v && !w;
    if (m_pend) begin m_rd = exp_read(a); m_tag = (tag == "") ? def_tag(a) : tag; end
    m_irq = wrp && m_tie;
    if (wrp) m_flag = 1;
    else if (cw || (v && !w && a[3:2] == 2'd0)) m_flag = 0;
    if (cw) m_cnt = 0;
    else if (stp) m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 1;
    if (v && w && a[3:2] == 2'd0) {m_src, m_tie, m_en} = d[2:0];
    if (v && w && a[3:2] == 2'd1) m_rel = d[23:0];
    m_s = {m_s[1:0], x};
    @(negedge clk);
    check(irq === m_irq, "R7", {31'b0, irq}, {31'b0, m_irq});
    if (m_pend) check(bus_rdata === m_rd, m_tag, bus_rdata, m_rd);
  endtask

  task automatic idle(int n, bit x = 0);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, x);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    {m_en, m_tie, m_src, m_flag, m_irq, m_pend} = '0;
    m_rel = 0; m_cnt = 0; m_s = 0; m_rd = 0;
    process::self().srandom(32'd7);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(irq === 1'b0, "R1", {31'b0, irq}, 0);
    cyc(1, 0, 4'h0, 0, 0, "R1");
    cyc(1, 0, 4'h4, 0, 0, "R1");
    cyc(1, 0, 4'h8, 0, 0, "R1");
    cyc(1, 0, 4'hC, 0, 0, "R4");
    cyc(1, 1, 4'hC, 32'hFFFF_FFFF, 0);
    cyc(1, 0, 4'hC, 0, 0, "R4");
    cyc(1, 1, 4'h4, 32'hFFFF_FF05, 0);
    cyc(1, 0, 4'h4, 0, 0, "R3");
    cyc(1, 1, 4'h4, 32'd3, 0);
    cyc(1, 1, 4'h0, 32'h0001_0005, 0);
    cyc(1, 0, 4'h0, 0, 0, "R2");
    idle(9);
    cyc(1, 1, 4'h0, 32'd7, 0);
    cyc(1, 0, 4'h0, 0, 0, "R2");
    idle(10);
    for (int i = 0; i < 12; i++) cyc(1, 0, 4'h0, 0, 0, "R8");
    cyc(1, 1, 4'h8, 32'hDEAD_BEEF, 0);
    cyc(1, 0, 4'h8, 0, 0, "R5");
    cyc(1, 0, 4'h0, 0, 0, "R5");
    cyc(1, 1, 4'h4, 32'd0, 0);
    cyc(1, 1, 4'h8, 32'd0, 0);
    idle(10);
    cyc(1, 0, 4'h8, 0, 0, "R9");
    cyc(1, 0, 4'h0, 0, 0, "R9");
    cyc(1, 1, 4'h4, 32'd2, 0);
    cyc(1, 1, 4'h0, 32'd3, 0);
    for (int i = 0; i < 16; i++) begin
      idle(3, i[0]);
      cyc(1, 0, 4'h8, 0, i[0], "R10");
    end
    cyc(1, 1, 4'h0, 32'd0, 0);
    cyc(1, 0, 4'h8, 0, 0, "R6");
    idle(5);
    cyc(1, 0, 4'h8, 0, 0, "R6");
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] a;
      logic [31:0] d;
      bit v, w;
      v = ($urandom_range(0, 1) == 1);
      w = ($urandom_range(0, 9) < 3);
      a = {2'($urandom_range(0, 3)), 2'b00};
      d = $urandom;
      if (a[3:2] == 2'd0) d[0] = ($urandom_range(0, 7) != 0);
      if (a[3:2] == 2'd1) d = $urandom_range(0, 6) | (32'($urandom_range(0, 1)) << 28);
      cyc(v, w, a, d, ($urandom_range(0, 3) == 0) ? ~ext_ref : ext_ref);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule